// File: doc/BRIEF.md
# Host Bus Register and Memory Access Decoder

This block sits between an asynchronous host processor bus and the internals of a time-slot switch. The host drives an active-low chip select, a read/write select, a 14-bit address and write data. The block brings the chip select into the core clock domain and decodes the address. The address reaches either the control register or one of two switch memories. For data memory accesses it issues a one-cycle read strobe. For connection memory accesses it issues a one-cycle write strobe. It then tells the host the transfer is complete by raising an acknowledge drive enable. The pad drives the acknowledge line low while that enable is high and leaves the line floating otherwise.

The top address bit splits the space in two. With that bit clear, the low bits select a register. With it set, the low thirteen bits form a memory address: a five-bit stream number above an eight-bit channel number. The memory-select field of the control register picks which memory that address reaches. The data memory can only be read and the connection memory can only be written. The control register fields are brought out as configuration outputs for the rest of the switch.

Top module: `hbus_access_dec`

## Requirements
- R1: While and just after reset, `ack_en`, `dmem_rd_en` and `cmem_wr_en` are low, `rdata` is zero and every configuration output is zero.
- R2: With default parameters, `ack_en` rises on the fifth rising clock edge, counting the first edge that samples `cs_n` low. No strobe is active in the cycle where it rises.
- R3: After `cs_n` returns high, `ack_en` falls on the third rising edge, counting the first edge that samples `cs_n` high. `rdata` holds steady while `ack_en` is high and reads zero while it is low.
- R4: `rw_n` high means read and low means write. With `addr[13]`=0 and `addr[12:0]`=0 the access reaches the control register. Its field positions are: bits 2:0 `cfg_rate`, bit 3 `cfg_wide_fp`, bit 4 `cfg_standby`, bit 5 `cfg_sfe`, bits 7:6 `cfg_mem_sel`, bit 8 `cfg_mbp`, bit 9 `cfg_bp_en`, bits 12:10 `cfg_bp_data`. Bits 15:13 are not stored and read zero.
- R5: A register-space access with a nonzero `addr[12:0]` reads zero, and a write there leaves the control register unchanged.
- R6: With `cfg_mem_sel`=00, a memory-space read pulses `dmem_rd_en` with `dmem_addr`=`addr[12:0]` (stream in 12:8, channel in 7:0). It returns the memory's data, which arrives one clock after the strobe.
- R7: With `cfg_mem_sel`=00, a memory-space write issues no strobe and changes no state.
- R8: With `cfg_mem_sel`=01, a memory-space write pulses `cmem_wr_en` with `cmem_addr`=`addr[12:0]` and `cmem_wdata` equal to the write data. A memory-space read issues no strobe and returns zero.
- R9: With `cfg_mem_sel` of 10 or 11, memory-space accesses issue no strobe and read zero.
- R10: A strobe lasts exactly one cycle, is issued once per bus cycle, and the two strobes are never high together.
- R11: If `cs_n` is low for at most ACK_DLY consecutive sampling edges, `ack_en` never rises for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| rw_n | input | 1 | Host direction: 1 read, 0 write |
| addr | input | 14 | Host address |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data, valid while `ack_en` is high |
| ack_en | output | 1 | Enable for the acknowledge pad to drive low |
| dmem_rd_en | output | 1 | Data memory read strobe |
| dmem_addr | output | 13 | Data memory address {stream, channel} |
| dmem_rdata | input | 16 | Data memory read data, one clock after the strobe |
| cmem_wr_en | output | 1 | Connection memory write strobe |
| cmem_addr | output | 13 | Connection memory address {stream, channel} |
| cmem_wdata | output | 16 | Connection memory write data |
| cfg_rate | output | 3 | Data-rate field |
| cfg_wide_fp | output | 1 | Wide frame pulse enable |
| cfg_standby | output | 1 | Output standby |
| cfg_sfe | output | 1 | Start-frame evaluation |
| cfg_mem_sel | output | 2 | Memory select for memory space |
| cfg_mbp | output | 1 | Memory block programming |
| cfg_bp_en | output | 1 | Block programming enable |
| cfg_bp_data | output | 3 | Block programming data |

## Verification
The checks assume the host behaves like a real bus master. Address, direction and write data are set before `cs_n` falls and held until `cs_n` rises. `cs_n` stays high for more than three edges between cycles, and the host starts a new cycle only after the acknowledge has been released. The stimulus task changes every bus input on the falling clock edge, all in the same step, and waits for the acknowledge to fall before it returns. The short chip-select case is the only one that breaks the hold rule on purpose, and no assertion depends on a completed handshake there.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    localparam int CTRL_W = 13;

    localparam logic [1:0] MSEL_DATA = 2'b00;
    localparam logic [1:0] MSEL_CONN = 2'b01;

    // packed MSB first: field positions are the register layout
    typedef struct packed {
        logic [2:0] bp_data;   // 12:10
        logic       bp_en;     // 9
        logic       mbp;       // 8
        logic [1:0] mem_sel;   // 7:6
        logic       sfe;       // 5
        logic       standby;   // 4
        logic       wide_fp;   // 3
        logic [2:0] rate;      // 2:0
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2
    } bus_st_e;

    typedef enum logic [1:0] {
        TGT_CTRL = 2'd0,
        TGT_NONE = 2'd1,
        TGT_DMEM = 2'd2,
        TGT_CMEM = 2'd3
    } tgt_e;

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[i] <= '0;
                else        stg_q[i] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[i] <= '0;
                else        stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/hbus_decode.sv
module hbus_decode
    import hbus_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int STREAM_W = 5,
    parameter int CHAN_W   = 8,
    localparam int MEM_AW  = STREAM_W + CHAN_W,
    localparam int REG_AW  = ADDR_W - 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rw_n_i,
    input  logic [1:0]        mem_sel_i,
    output tgt_e              tgt_o,
    output logic [MEM_AW-1:0] mem_addr_o
);

    logic mem_space;
    logic [STREAM_W-1:0] stream;
    logic [CHAN_W-1:0]   chan;

    assign mem_space  = addr_i[ADDR_W-1];
    assign chan       = addr_i[CHAN_W-1:0];
    assign stream     = addr_i[MEM_AW-1:CHAN_W];
    assign mem_addr_o = {stream, chan};

    always_comb begin
        tgt_o = TGT_NONE;
        if (!mem_space) begin
            if (addr_i[REG_AW-1:0] == '0) tgt_o = TGT_CTRL;
        end else begin
            unique case (mem_sel_i)
                MSEL_DATA: tgt_o = rw_n_i ? TGT_DMEM : TGT_NONE;
                MSEL_CONN: tgt_o = rw_n_i ? TGT_NONE : TGT_CMEM;
                default:   tgt_o = TGT_NONE;
            endcase
        end
    end

endmodule

// File: rtl/hbus_ctrl_reg.sv
module hbus_ctrl_reg
    import hbus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output ctrl_t             ctrl_o,
    output logic [DATA_W-1:0] rdata_o
);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (we_i) ctrl_d = ctrl_t'(wdata_i[CTRL_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_o  = ctrl_q;
    assign rdata_o = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};

endmodule

// File: rtl/hbus_access_dec.sv
module hbus_access_dec
    import hbus_pkg::*;
#(
    parameter int ADDR_W      = 14,
    parameter int DATA_W      = 16,
    parameter int STREAM_W    = 5,
    parameter int CHAN_W      = 8,
    parameter int ACK_DLY     = 2,
    parameter int SYNC_STAGES = 2,
    localparam int MEM_AW     = STREAM_W + CHAN_W,
    localparam int CNT_W      = $clog2(ACK_DLY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rw_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ack_en,
    output logic              dmem_rd_en,
    output logic [MEM_AW-1:0] dmem_addr,
    input  logic [DATA_W-1:0] dmem_rdata,
    output logic              cmem_wr_en,
    output logic [MEM_AW-1:0] cmem_addr,
    output logic [DATA_W-1:0] cmem_wdata,
    output logic [2:0]        cfg_rate,
    output logic              cfg_wide_fp,
    output logic              cfg_standby,
    output logic              cfg_sfe,
    output logic [1:0]        cfg_mem_sel,
    output logic              cfg_mbp,
    output logic              cfg_bp_en,
    output logic [2:0]        cfg_bp_data
);

    typedef struct packed {
        bus_st_e             st;
        logic [CNT_W-1:0]    cnt;
        tgt_e                tgt;
        logic                is_rd;
        logic [MEM_AW-1:0]   maddr;
        logic [DATA_W-1:0]   wdat;
        logic                rd_stb;
        logic                wr_stb;
        logic                reg_we;
        logic                ack;
        logic [DATA_W-1:0]   rdat;
    } fsm_t;

    fsm_t s_d, s_q;

    logic              cs_act;
    tgt_e              dec_tgt;
    logic [MEM_AW-1:0] dec_maddr;
    ctrl_t             ctrl;
    logic [DATA_W-1:0] ctrl_rdata;

    hbus_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_cs_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (~cs_n),
        .q_o   (cs_act)
    );

    hbus_decode #(.ADDR_W(ADDR_W), .STREAM_W(STREAM_W), .CHAN_W(CHAN_W)) u_decode (
        .addr_i     (addr),
        .rw_n_i     (rw_n),
        .mem_sel_i  (ctrl.mem_sel),
        .tgt_o      (dec_tgt),
        .mem_addr_o (dec_maddr)
    );

    hbus_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (s_q.reg_we),
        .wdata_i (s_q.wdat),
        .ctrl_o  (ctrl),
        .rdata_o (ctrl_rdata)
    );

    always_comb begin
        s_d        = s_q;
        s_d.rd_stb = 1'b0;
        s_d.wr_stb = 1'b0;
        s_d.reg_we = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (cs_act) begin
                    s_d.st     = ST_WAIT;
                    s_d.cnt    = '0;
                    s_d.tgt    = dec_tgt;
                    s_d.is_rd  = rw_n;
                    s_d.maddr  = dec_maddr;
                    s_d.wdat   = wdata;
                    s_d.rd_stb = (dec_tgt == TGT_DMEM);
                    s_d.wr_stb = (dec_tgt == TGT_CMEM);
                    s_d.reg_we = (dec_tgt == TGT_CTRL) && !rw_n;
                end
            end
            ST_WAIT: begin
                if (!cs_act) begin
                    s_d.st = ST_IDLE;
                end else if (s_q.cnt == CNT_W'(ACK_DLY - 1)) begin
                    s_d.st  = ST_ACK;
                    s_d.ack = 1'b1;
                    s_d.rdat = '0;
                    if (s_q.is_rd) begin
                        unique case (s_q.tgt)
                            TGT_CTRL: s_d.rdat = ctrl_rdata;
                            TGT_DMEM: s_d.rdat = dmem_rdata;
                            default:  s_d.rdat = '0;
                        endcase
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_ACK: begin
                if (!cs_act) begin
                    s_d.st   = ST_IDLE;
                    s_d.ack  = 1'b0;
                    s_d.rdat = '0;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.st  <= ST_IDLE;
            s_q.tgt <= TGT_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata       = s_q.rdat;
    assign ack_en      = s_q.ack;
    assign dmem_rd_en  = s_q.rd_stb;
    assign dmem_addr   = s_q.maddr;
    assign cmem_wr_en  = s_q.wr_stb;
    assign cmem_addr   = s_q.maddr;
    assign cmem_wdata  = s_q.wdat;

    assign cfg_rate    = ctrl.rate;
    assign cfg_wide_fp = ctrl.wide_fp;
    assign cfg_standby = ctrl.standby;
    assign cfg_sfe     = ctrl.sfe;
    assign cfg_mem_sel = ctrl.mem_sel;
    assign cfg_mbp     = ctrl.mbp;
    assign cfg_bp_en   = ctrl.bp_en;
    assign cfg_bp_data = ctrl.bp_data;

endmodule

// File: rtl/hbus_access_chk.sv
module hbus_access_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              ack_en,
    input logic [DATA_W-1:0] rdata,
    input logic              dmem_rd_en,
    input logic              cmem_wr_en,
    input logic [1:0]        cfg_mem_sel
);

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_rd_en || cmem_wr_en) |=> !(dmem_rd_en || cmem_wr_en)); // R10

    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_rd_en && cmem_wr_en)); // R10

    AST_NO_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_rd_en || cmem_wr_en) |=> !ack_en); // R2

    AST_ACK_RELEASE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_en) |-> $past(cs_n, 3)); // R3

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_en && $past(ack_en)) |-> $stable(rdata)); // R3

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_en |-> (rdata == '0)); // R3

    AST_DMEM_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_rd_en |-> (cfg_mem_sel == 2'b00)); // R6

    AST_CMEM_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        cmem_wr_en |-> (cfg_mem_sel == 2'b01)); // R8

endmodule

bind hbus_access_dec hbus_access_chk #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .ack_en      (ack_en),
    .rdata       (rdata),
    .dmem_rd_en  (dmem_rd_en),
    .cmem_wr_en  (cmem_wr_en),
    .cfg_mem_sel (cfg_mem_sel)
);

// File: tb/hbus_access_dec_tb.sv
`timescale 1ns/1ps
module hbus_access_dec_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rw_n = 1'b1;
    logic [13:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ack_en;
    logic        dmem_rd_en;
    logic [12:0] dmem_addr;
    logic [15:0] dmem_rdata = '0;
    logic        cmem_wr_en;
    logic [12:0] cmem_addr;
    logic [15:0] cmem_wdata;
    logic [2:0]  cfg_rate;
    logic        cfg_wide_fp, cfg_standby, cfg_sfe, cfg_mbp, cfg_bp_en;
    logic [1:0]  cfg_mem_sel;
    logic [2:0]  cfg_bp_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hbus_access_dec dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw_n(rw_n), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ack_en(ack_en),
        .dmem_rd_en(dmem_rd_en), .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata),
        .cmem_wr_en(cmem_wr_en), .cmem_addr(cmem_addr), .cmem_wdata(cmem_wdata),
        .cfg_rate(cfg_rate), .cfg_wide_fp(cfg_wide_fp), .cfg_standby(cfg_standby),
        .cfg_sfe(cfg_sfe), .cfg_mem_sel(cfg_mem_sel), .cfg_mbp(cfg_mbp),
        .cfg_bp_en(cfg_bp_en), .cfg_bp_data(cfg_bp_data)
    );

    function automatic logic [15:0] mem_pat(input logic [12:0] a);
        return {3'b101, a} ^ 16'h5A5A;
    endfunction

    // data memory model: registered read, one clock after the strobe
    always_ff @(posedge clk) if (dmem_rd_en) dmem_rdata <= mem_pat(dmem_addr);

    int          d_cnt = 0, c_cnt = 0;
    logic [12:0] d_addr = '0, c_addr = '0;
    logic [15:0] c_data = '0;
    always @(posedge clk) begin
        if (dmem_rd_en) begin d_cnt++; d_addr = dmem_addr; end
        if (cmem_wr_en) begin c_cnt++; c_addr = cmem_addr; c_data = cmem_wdata; end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic bus_cycle(input logic rw, input logic [13:0] a, input logic [15:0] wd,
                             output logic [15:0] rd, output int lat, output int rel);
        @(negedge clk);
        d_cnt = 0; c_cnt = 0;
        rw_n = rw; addr = a; wdata = wd; cs_n = 1'b0;
        lat = 0;
        rd = '0;
        while (lat < 20) begin
            @(posedge clk); lat++;
            @(negedge clk);
            if (ack_en) break;
        end
        rd = rdata;
        cs_n = 1'b1;
        rel = 0;
        while (rel < 20) begin
            @(posedge clk); rel++;
            @(negedge clk);
            if (!ack_en) break;
        end
        repeat (2) @(negedge clk);
    endtask

    typedef struct packed {
        logic        rw;
        logic [13:0] addr;
        logic [15:0] wd;
        logic [15:0] erd;
        logic        ed;
        logic        ec;
        logic [15:0] tag;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 14'h0000, 16'hFFFF, 16'h0000, 1'b0, 1'b0, "R4"},
        '{1'b1, 14'h0000, 16'h0000, 16'h1FFF, 1'b0, 1'b0, "R4"},
        '{1'b1, 14'h2000, 16'h0000, 16'h0000, 1'b0, 1'b0, "R9"},
        '{1'b0, 14'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, "R4"},
        '{1'b1, 14'h2345, 16'h0000, 16'hFFFF, 1'b1, 1'b0, "R6"},
        '{1'b1, 14'h3FFF, 16'h0000, 16'hFFFF, 1'b1, 1'b0, "R6"},
        '{1'b0, 14'h2010, 16'hBEEF, 16'h0000, 1'b0, 1'b0, "R7"},
        '{1'b1, 14'h0001, 16'h0000, 16'h0000, 1'b0, 1'b0, "R5"},
        '{1'b0, 14'h1FFF, 16'h1234, 16'h0000, 1'b0, 1'b0, "R5"},
        '{1'b1, 14'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, "R5"},
        '{1'b0, 14'h0000, 16'h0040, 16'h0000, 1'b0, 1'b0, "R4"},
        '{1'b0, 14'h2A7C, 16'hC0DE, 16'h0000, 1'b0, 1'b1, "R8"},
        '{1'b1, 14'h2A7C, 16'h0000, 16'h0000, 1'b0, 1'b0, "R8"},
        '{1'b1, 14'h0000, 16'h0000, 16'h0040, 1'b0, 1'b0, "R4"},
        '{1'b0, 14'h0000, 16'h0080, 16'h0000, 1'b0, 1'b0, "R4"},
        '{1'b0, 14'h2001, 16'h1111, 16'h0000, 1'b0, 1'b0, "R9"},
        '{1'b1, 14'h2001, 16'h0000, 16'h0000, 1'b0, 1'b0, "R9"}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        int lat, rel;
        string tg;

        repeat (3) @(negedge clk);
        chk(ack_en == 1'b0 && dmem_rd_en == 1'b0 && cmem_wr_en == 1'b0, "R1", "in reset strobes/ack",
            {ack_en, dmem_rd_en, cmem_wr_en}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(rdata == 16'h0, "R1", "rdata after reset", rdata, 0);
        chk({cfg_bp_data, cfg_bp_en, cfg_mbp, cfg_mem_sel, cfg_sfe, cfg_standby, cfg_wide_fp, cfg_rate} == 13'h0,
            "R1", "cfg after reset",
            {cfg_bp_data, cfg_bp_en, cfg_mbp, cfg_mem_sel, cfg_sfe, cfg_standby, cfg_wide_fp, cfg_rate}, 0);

        for (int i = 0; i < NV; i++) begin
            tg = $sformatf("%s", VECS[i].tag);
            bus_cycle(VECS[i].rw, VECS[i].addr, VECS[i].wd, rd, lat, rel);
            chk(lat == 5, "R2", $sformatf("ack latency v%0d", i), lat, 5);
            chk(rel == 3, "R3", $sformatf("ack release v%0d", i), rel, 3);
            chk(d_cnt == int'(VECS[i].ed), "R10", $sformatf("dmem strobe count v%0d", i), d_cnt, VECS[i].ed);
            chk(c_cnt == int'(VECS[i].ec), "R10", $sformatf("cmem strobe count v%0d", i), c_cnt, VECS[i].ec);
            if (VECS[i].ed) begin
                chk(d_addr == VECS[i].addr[12:0], tg, $sformatf("dmem addr v%0d", i), d_addr, VECS[i].addr[12:0]);
                chk(rd == mem_pat(VECS[i].addr[12:0]), tg, $sformatf("mem rdata v%0d", i),
                    rd, mem_pat(VECS[i].addr[12:0]));
            end else if (VECS[i].rw) begin
                chk(rd == VECS[i].erd, tg, $sformatf("rdata v%0d", i), rd, VECS[i].erd);
            end
            if (VECS[i].ec) begin
                chk(c_addr == VECS[i].addr[12:0], tg, $sformatf("cmem addr v%0d", i), c_addr, VECS[i].addr[12:0]);
                chk(c_data == VECS[i].wd, tg, $sformatf("cmem data v%0d", i), c_data, VECS[i].wd);
            end
        end

        // R4 field positions
        bus_cycle(1'b0, 14'h0000, 16'h1235, rd, lat, rel);
        chk(cfg_rate == 3'd5 && cfg_wide_fp == 1'b0 && cfg_standby == 1'b1 && cfg_sfe == 1'b1,
            "R4", "low fields", {cfg_sfe, cfg_standby, cfg_wide_fp, cfg_rate}, 6'b110101);
        chk(cfg_mem_sel == 2'b00 && cfg_mbp == 1'b0 && cfg_bp_en == 1'b1 && cfg_bp_data == 3'd4,
            "R4", "high fields", {cfg_bp_data, cfg_bp_en, cfg_mbp, cfg_mem_sel}, 7'b1001000);

        // R11: chip select low for exactly ACK_DLY sampling edges
        @(negedge clk);
        rw_n = 1'b1; addr = 14'h0000; cs_n = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        begin
            bit seen = 1'b0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (ack_en) seen = 1'b1;
            end
            chk(!seen, "R11", "short chip select acked", seen, 0);
        end

        // normal cycle still works after the aborted one
        bus_cycle(1'b1, 14'h0000, 16'h0, rd, lat, rel);
        chk(lat == 5 && rd == 16'h1235, "R11", "cycle after abort", {lat[15:0], rd}, {16'd5, 16'h1235});

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule